// File: doc/BRIEF.md
# Fully Associative Tag Store with Rotating Victim Pointer

This block is a small cache in which any block address may occupy any entry. Each entry holds a valid flag, the full block address as its tag, and one data word. A lookup compares the requested address against every entry at once. One clock later, the block reports whether a valid entry matched and returns that entry's word.

A fill installs an address and word. If the address is already present, its word is overwritten in place. If it is absent, the word goes to the lowest-numbered empty entry, so entries fill up in ascending order. Once every entry is valid, a fill evicts the entry named by a rotating replacement pointer.

The pointer advances by one, wrapping from the last entry to entry 0, whenever an access touches the entry it names. An access is either a lookup hit or a fill that writes that entry. Accesses to any other entry leave the pointer where it is. A flush invalidates everything and returns the pointer to entry 0.

Top module: `fa_cache`

## Requirements
- R1: After reset, hit_o and data_o are 0, every entry is invalid, and the replacement pointer names entry 0.
- R2: A lookup (lookup_i=1, fill_i=0) in cycle t gives hit_o=1 in cycle t+1, with data_o equal to the word of the valid entry whose tag equals lookup_tag_i. With no such entry, hit_o=0 and data_o=0. In every cycle following a non-lookup cycle, hit_o=0 and data_o=0. lookup_i and fill_i are never both 1.
- R3: An invalid entry never matches, whatever tag it holds; after a flush, every previously stored address misses.
- R4: A fill of an absent address writes the lowest-numbered invalid entry, so entries are occupied in ascending index order after a flush or reset.
- R5: No valid entry is overwritten by a fill while an invalid entry exists; the number of valid entries rises by one per fill of an absent address.
- R6: When all entries are valid, a fill of an absent address replaces the entry named by the pointer.
- R7: A lookup hit on the pointed entry advances the pointer by one, from the last entry to entry 0; a hit on any other entry, or a miss, leaves it unchanged.
- R8: A fill that writes the pointed entry (empty slot, in-place update or replacement) advances the pointer the same way.
- R9: A fill of an address already valid in the cache overwrites that entry's word and does not create a second entry.
- R10: flush_i=1 clears every valid bit and sets the pointer to entry 0. It takes priority over a lookup or fill in the same cycle: the fill is dropped and the lookup reports a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lookup_i | input | 1 | Lookup request |
| lookup_tag_i | input | TAG_W | Block address to look up |
| fill_i | input | 1 | Install request |
| fill_tag_i | input | TAG_W | Block address to install |
| fill_data_i | input | DATA_W | Word to install |
| flush_i | input | 1 | Invalidate all entries, reset pointer |
| hit_o | output | 1 | Registered hit of the previous cycle's lookup |
| data_o | output | DATA_W | Registered word of the hit entry, 0 on miss |

## Verification
A flush can fall in the same cycle as a lookup or a fill, and the block must let the flush win. The bench provokes both collisions. It raises flush_i together with a lookup of a resident address and requires a miss. It raises flush_i together with a fill and then looks up the filled address, requiring a miss there too. In the random phase, flushes land on arbitrary operations. A behavioural reference model recomputes the expected hit and word every cycle; it also tracks pointer motion and eviction, and each output is compared against it.

// File: rtl/fa_cache_pkg.sv
`timescale 1ns/1ps
package fa_cache_pkg;
  typedef enum logic [1:0] {
    WR_NONE,
    WR_UPDATE,
    WR_EMPTY,
    WR_VICTIM
  } fill_kind_e;
endpackage

// File: rtl/fa_tag_match.sv
`timescale 1ns/1ps
module fa_tag_match #(
  parameter int ENTRIES = 64,
  parameter int TAG_W   = 30
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ENTRIES-1:0]  valid_i,
  input  logic [TAG_W-1:0]    tags_i [ENTRIES],
  input  logic [TAG_W-1:0]    key_i,
  output logic [ENTRIES-1:0]  match_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tags_i[g] == key_i);
  end

  // fills update in place, so no address is ever resident twice
  AST_SINGLE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_o)); // R9
endmodule

// File: rtl/fa_prio_sel.sv
`timescale 1ns/1ps
module fa_prio_sel #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] req_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/fa_repl_ptr.sv
`timescale 1ns/1ps
module fa_repl_ptr #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q;
  assign ptr_o = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (flush_i) begin
      ptr_q <= '0;
    end else if (touch_i && (touch_idx_i == ptr_q)) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  AST_PTR_FLUSH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (ptr_o == '0)); // R10
  AST_PTR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_o <= LAST); // R7
  AST_PTR_OTHER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && !touch_i) |=> $stable(ptr_o)); // R7
endmodule

// File: rtl/fa_cache.sv
`timescale 1ns/1ps
module fa_cache
  import fa_cache_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int TAG_W   = 30,
  parameter int DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_i,
  input  logic [TAG_W-1:0]  lookup_tag_i,
  input  logic              fill_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              flush_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [DATA_W-1:0]  word_q [ENTRIES];

  logic [TAG_W-1:0]   key;
  logic [ENTRIES-1:0] key_match;
  logic               key_found;
  logic [IDX_W-1:0]   key_idx;
  logic               empty_found;
  logic [IDX_W-1:0]   empty_idx;
  logic [IDX_W-1:0]   ptr;
  fill_kind_e         kind;
  logic [IDX_W-1:0]   wr_idx;
  logic               wr_en;
  logic               rd_hit;
  logic               touch;
  logic [IDX_W-1:0]   touch_idx;
  logic               hit_q;
  logic [DATA_W-1:0]  data_q;

  // one comparator bank serves both ports; they never share a cycle
  assign key = fill_i ? fill_tag_i : lookup_tag_i;

  fa_tag_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) i_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_q),
    .tags_i  (tag_q),
    .key_i   (key),
    .match_o (key_match)
  );

  fa_prio_sel #(.ENTRIES(ENTRIES)) i_hit_sel (
    .req_i   (key_match),
    .found_o (key_found),
    .idx_o   (key_idx)
  );

  fa_prio_sel #(.ENTRIES(ENTRIES)) i_empty_sel (
    .req_i   (~valid_q),
    .found_o (empty_found),
    .idx_o   (empty_idx)
  );

  always_comb begin
    if (!fill_i || flush_i) kind = WR_NONE;
    else if (key_found)     kind = WR_UPDATE;
    else if (empty_found)   kind = WR_EMPTY;
    else                    kind = WR_VICTIM;
  end

  always_comb begin
    case (kind)
      WR_UPDATE: wr_idx = key_idx;
      WR_EMPTY:  wr_idx = empty_idx;
      WR_VICTIM: wr_idx = ptr;
      default:   wr_idx = '0;
    endcase
  end

  assign wr_en     = (kind != WR_NONE);
  assign rd_hit    = lookup_i && !fill_i && !flush_i && key_found;
  assign touch     = wr_en || rd_hit;
  assign touch_idx = wr_en ? wr_idx : key_idx;

  fa_repl_ptr #(.ENTRIES(ENTRIES)) i_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .touch_i     (touch),
    .touch_idx_i (touch_idx),
    .ptr_o       (ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= fill_tag_i;
      word_q[wr_idx] <= fill_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= 1'b0;
      data_q <= '0;
    end else begin
      hit_q  <= rd_hit;
      data_q <= rd_hit ? word_q[key_idx] : '0;
    end
  end

  assign hit_o  = hit_q;
  assign data_o = data_q;

  AST_NO_FILL_WITH_LOOKUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_i && lookup_i)); // R2
  AST_HIT_NEEDS_LOOKUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_i |=> !hit_o); // R2
  AST_FLUSH_INVALIDATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0)); // R10
  AST_EMPTY_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !flush_i && !key_found && !(&valid_q))
      |=> ($countones(valid_q) == $countones($past(valid_q)) + 1)); // R5
  AST_FULL_STAYS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !flush_i && (&valid_q)) |=> (&valid_q)); // R6
endmodule

// File: tb/test_fa_cache.sv
`timescale 1ns/1ps
module test_fa_cache;
  localparam int N  = 8;
  localparam int TW = 12;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lookup = 1'b0;
  logic [TW-1:0] lookup_tag = '0;
  logic          fill = 1'b0;
  logic [TW-1:0] fill_tag = '0;
  logic [DW-1:0] fill_data = '0;
  logic          flush = 1'b0;
  logic          hit;
  logic [DW-1:0] data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // reference model
  bit            m_valid [N];
  logic [TW-1:0] m_tag   [N];
  logic [DW-1:0] m_data  [N];
  int            m_ptr;

  always #4 clk = ~clk;

  fa_cache #(.ENTRIES(N), .TAG_W(TW), .DATA_W(DW)) i_fa_cache (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .lookup_i     (lookup),
    .lookup_tag_i (lookup_tag),
    .fill_i       (fill),
    .fill_tag_i   (fill_tag),
    .fill_data_i  (fill_data),
    .flush_i      (flush),
    .hit_o        (hit),
    .data_o       (data)
  );

  function automatic int find(logic [TW-1:0] t);
    for (int i = 0; i < N; i++) if (m_valid[i] && m_tag[i] == t) return i;
    return -1;
  endfunction

  function automatic void touch(int i);
    if (i == m_ptr) m_ptr = (m_ptr + 1) % N;
  endfunction

  task automatic check(bit eh, logic [DW-1:0] ed, string req);
    n_checks++;
    if (hit !== eh || data !== ed) begin
      n_fail++;
      $display("FAIL %s: hit=%0b data=%h expected hit=%0b data=%h", req, hit, data, eh, ed);
    end
  endtask

  // called at a negedge; returns at the following negedge after checking
  task automatic step(bit lk, logic [TW-1:0] lt, bit fl, logic [TW-1:0] ft,
                      logic [DW-1:0] fd, bit fs, string req);
    bit eh;
    logic [DW-1:0] ed;
    int i;
    lookup = lk; lookup_tag = lt; fill = fl; fill_tag = ft; fill_data = fd; flush = fs;
    eh = 1'b0; ed = '0;
    if (fs) begin
      for (int k = 0; k < N; k++) m_valid[k] = 1'b0;
      m_ptr = 0;
    end else if (lk) begin
      i = find(lt);
      if (i >= 0) begin eh = 1'b1; ed = m_data[i]; touch(i); end
    end else if (fl) begin
      i = find(ft);
      if (i < 0) begin
        for (int k = N - 1; k >= 0; k--) if (!m_valid[k]) i = k;
        if (i < 0) i = m_ptr;
      end
      m_valid[i] = 1'b1; m_tag[i] = ft; m_data[i] = fd;
      touch(i);
    end
    @(posedge clk);
    @(negedge clk);
    lookup = 1'b0; fill = 1'b0; flush = 1'b0;
    check(eh, ed, req);
  endtask

  task automatic do_look(logic [TW-1:0] t, string req);
    step(1'b1, t, 1'b0, '0, '0, 1'b0, req);
  endtask

  task automatic do_fill(logic [TW-1:0] t, logic [DW-1:0] d, string req);
    step(1'b0, '0, 1'b1, t, d, 1'b0, req);
  endtask

  // explicit expectation, independent of the model
  task automatic expect_look(logic [TW-1:0] t, bit eh, logic [DW-1:0] ed, string req);
    do_look(t, req);
    n_checks++;
    if (hit !== eh || data !== ed) begin
      n_fail++;
      $display("FAIL %s: tag=%h hit=%0b data=%h expected hit=%0b data=%h",
               req, t, hit, data, eh, ed);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    for (int k = 0; k < N; k++) begin m_valid[k] = 1'b0; m_tag[k] = '0; m_data[k] = '0; end
    m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(1'b0, '0, "R1");
    expect_look(12'h000, 1'b0, '0, "R1");

    // fill all entries: ascending placement, nothing lost
    for (int k = 0; k < N; k++) do_fill(12'h100 + TW'(k), 16'hA000 + DW'(k), "R4");
    for (int k = 0; k < N; k++) expect_look(12'h100 + TW'(k), 1'b1, 16'hA000 + DW'(k), "R5");
    expect_look(12'h3FF, 1'b0, '0, "R2");

    // full: pointer wrapped to 0 by fill touches, then advanced by lookup of entry 0
    // (entry 0 hit at pointer 0 -> pointer 1); lookups 1..7 walk it around to 0
    do_fill(12'h200, 16'hB000, "R6");
    expect_look(12'h100, 1'b0, '0, "R6");
    expect_look(12'h200, 1'b1, 16'hB000, "R6");

    // pointer now 1; hit on non-pointed entry leaves it
    do_look(12'h105, "R7");
    do_look(12'h101, "R7");
    do_fill(12'h201, 16'hB001, "R8");
    expect_look(12'h102, 1'b0, '0, "R7");
    expect_look(12'h101, 1'b1, 16'hA001, "R7");

    // in-place update
    do_fill(12'h103, 16'hC003, "R9");
    expect_look(12'h103, 1'b1, 16'hC003, "R9");
    for (int k = 4; k < N; k++) do_look(12'h100 + TW'(k), "R9");

    // wrap: hit each pointed entry in turn
    for (int r = 0; r < 2 * N; r++)
      for (int k = 0; k < N; k++) do_look(m_tag[m_ptr], "R7");
    do_fill(12'h2AA, 16'hD0AA, "R8");

    // flush collisions
    step(1'b1, 12'h200, 1'b0, '0, '0, 1'b1, "R10");
    expect_look(12'h200, 1'b0, '0, "R3");
    expect_look(12'h105, 1'b0, '0, "R3");
    step(1'b0, '0, 1'b1, 12'h333, 16'hE333, 1'b1, "R10");
    expect_look(12'h333, 1'b0, '0, "R10");
    do_fill(12'h044, 16'h0044, "R4");
    expect_look(12'h044, 1'b1, 16'h0044, "R2");

    // random traffic on a small address space
    for (int c = 0; c < 2000; c++) begin
      int op;
      logic [TW-1:0] t;
      op = $urandom_range(0, 99);
      t  = TW'($urandom_range(0, 13));
      if (op < 50)      do_look(t, "R2");
      else if (op < 97) do_fill(t, DW'($urandom), "R6");
      else if (op < 98) step(1'b1, t, 1'b0, '0, '0, 1'b1, "R10");
      else if (op < 99) step(1'b0, '0, 1'b1, t, DW'($urandom), 1'b1, "R10");
      else              step(1'b0, '0, 1'b0, '0, '0, 1'b0, "R2");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule